// File: doc/BRIEF.md
# External Pin Interrupt Controller

The block watches 32 external pins, grouped into four banks of eight. It turns pin activity into interrupt requests for a parent interrupt controller. Each pin is first passed through a two-stage synchroniser. It is then compared against a programmable trigger condition: a level, a single edge or either edge. When the condition is met, the pin's sticky pending bit is set. A per-pin mask bit decides whether that pending bit reaches an interrupt output. Pins 0 to 15 each own a dedicated output. Pins 16 to 31 share a single output, which is the OR of their unmasked pending bits.

Software programs the block over a plain register bus with single-cycle requests. A write happens on the clock edge where `bus_sel` and `bus_wr` are both high. A read is requested with `bus_sel` high and `bus_wr` low; the data appears on `bus_rdata` one clock later and is held until the next read. The bus has no back-pressure: every request is accepted in the cycle it is presented.

The address is `{kind[1:0], bank[1:0]}`. The kind values are: 0 is the trigger configuration word, 1 is the mask byte and 2 is the pending byte. Kind 3 reads as zero and ignores writes.

Top module: `eint_ctrl`

## Requirements
- R1: After reset, every pending bit is 0, every mask bit is 1 and every configuration field is 0 (level low). All interrupt outputs are low.
- R2: In a bank's configuration word, pin p (p = 0..7) owns the 3-bit field at bits 4p+2..4p. Bit 4p+3 is not stored and reads back as 0.
- R3: Code 0 (level low) and code 1 (level high) set the pending bit on every clock while the synchronised pin sits at that level. The bit therefore comes back right after a write-one clear while the level persists.
- R4: Code 3 (rising) sets pending only on a 0-to-1 transition, and code 2 (falling) only on a 1-to-0 transition. A pin change made between two clock edges shows up as pending after the third following rising clock edge.
- R5: Code 4 (both edges) sets pending on either transition.
- R6: Codes 5, 6 and 7 never set pending, whatever the pin does.
- R7: A mask bit of 1 keeps the pin's output low but does not stop the pending bit from being captured. Clearing the mask to 0 exposes a pending bit that is already set.
- R8: A write of 1 to a pending bit clears it, and a write of 0 leaves it unchanged. When a set and a clear happen in the same cycle, the set wins.
- R9: Dedicated output bit k (k = 0..15) is high exactly when pin k is pending and unmasked.
- R10: The shared output is high exactly when any of pins 16..31 is pending and unmasked.
- R11: Read data appears one cycle after the read request and stays stable while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins | input | 32 | Asynchronous external pin levels |
| bus_sel | input | 1 | Register request strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | {kind, bank} register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_ded | output | 16 | Per-pin outputs for pins 0..15 |
| irq_shared | output | 1 | Combined output for pins 16..31 |

## Verification
Timing is measured in rising clock edges after a change.

- **Pin changes.** A pin change driven on a falling clock edge becomes pending on the third rising edge. The bench checks the shared output after two edges, where it must still be low, and then after three, where it must be high.
- **Register writes.** A write takes effect on the next edge, so mask and clear effects are checked at the following falling edge.
- **Reads.** Read data is registered. Every read pushes its expected word into a scoreboard queue, and a monitor pops and compares the word on the falling edge after the capturing rising edge.
- **Stimulus spacing.** All stimulus is applied on falling edges and held for at least three cycles before a result is checked.

// File: rtl/eint_pkg.sv
package eint_pkg;
  typedef enum logic [2:0] {
    TRIG_LVL_LO = 3'd0,
    TRIG_LVL_HI = 3'd1,
    TRIG_FALL   = 3'd2,
    TRIG_RISE   = 3'd3,
    TRIG_BOTH   = 3'd4
  } trig_e;

  typedef enum logic [1:0] {
    KIND_CFG  = 2'd0,
    KIND_MASK = 2'd1,
    KIND_PEND = 2'd2,
    KIND_NONE = 2'd3
  } reg_kind_e;

  localparam int unsigned FIELD_W = 4;
  localparam int unsigned CODE_W  = 3;
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_async;
      stab_q <= meta_q;
    end
  end

  assign d_sync = stab_q;
endmodule

// File: rtl/eint_bank.sv
module eint_bank
  import eint_pkg::*;
#(
  parameter int unsigned PINS = 8,
  parameter int unsigned DW   = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pin_s,
  input  logic            cfg_we,
  input  logic            mask_we,
  input  logic            pend_we,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   cfg_word,
  output logic [PINS-1:0] mask_q,
  output logic [PINS-1:0] pend_q
);
  logic [PINS-1:0][CODE_W-1:0] cfg_q;
  logic [PINS-1:0]             prev_q;
  logic [PINS-1:0]             set_req;
  logic [PINS-1:0]             clr_req;

  // Trigger decode, one per pin
  for (genvar i = 0; i < PINS; i++) begin : g_pin
    always_comb begin
      case (cfg_q[i])
        TRIG_LVL_LO: set_req[i] = ~pin_s[i];
        TRIG_LVL_HI: set_req[i] = pin_s[i];
        TRIG_FALL:   set_req[i] = prev_q[i] & ~pin_s[i];
        TRIG_RISE:   set_req[i] = ~prev_q[i] & pin_s[i];
        TRIG_BOTH:   set_req[i] = prev_q[i] ^ pin_s[i];
        default:     set_req[i] = 1'b0;
      endcase
    end

    assign cfg_word[FIELD_W*i +: FIELD_W] = {1'b0, cfg_q[i]};

    // R3
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (cfg_q[i] == TRIG_LVL_HI && pin_s[i]) |=> pend_q[i]);
    // R4
    rise_set_chk: assert property (@(posedge clk) disable iff (rst)
      (cfg_q[i] == TRIG_RISE && pin_s[i] && !prev_q[i]) |=> pend_q[i]);
    // R6
    bad_code_chk: assert property (@(posedge clk) disable iff (rst)
      (cfg_q[i] > TRIG_BOTH && !pend_q[i]) |=> !pend_q[i]);
  end

  if (DW > FIELD_W * PINS) begin : g_pad
    assign cfg_word[DW-1:FIELD_W*PINS] = '0;
  end

  assign clr_req = pend_we ? wdata[PINS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      mask_q <= '1;
      pend_q <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= pin_s;
      pend_q <= (pend_q & ~clr_req) | set_req;
      if (mask_we) mask_q <= wdata[PINS-1:0];
      if (cfg_we) begin
        for (int i = 0; i < PINS; i++) begin
          cfg_q[i] <= wdata[FIELD_W*i +: CODE_W];
        end
      end
    end
  end

  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(pend_we) |-> ((pend_q & $past(wdata[PINS-1:0]) & ~$past(set_req)) == '0));
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '1 && pend_q == '0));
endmodule

// File: rtl/eint_rdmux.sv
module eint_rdmux
  import eint_pkg::*;
#(
  parameter int unsigned BANKS = 4,
  parameter int unsigned PINS  = 8,
  parameter int unsigned DW    = 32,
  localparam int unsigned BAW  = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  reg_kind_e                   kind,
  input  logic [BAW-1:0]              bank,
  input  logic [BANKS-1:0][DW-1:0]    cfg_words,
  input  logic [BANKS-1:0][PINS-1:0]  masks,
  input  logic [BANKS-1:0][PINS-1:0]  pends,
  output logic [DW-1:0]               word
);
  always_comb begin
    word = '0;
    if (32'(bank) < BANKS) begin
      case (kind)
        KIND_CFG:  word = cfg_words[bank];
        KIND_MASK: word[PINS-1:0] = masks[bank];
        KIND_PEND: word[PINS-1:0] = pends[bank];
        default:   word = '0;
      endcase
    end
  end
endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
  import eint_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_PINS = 8,
  parameter int unsigned DED_PINS  = 16,
  parameter int unsigned DW        = 32,
  localparam int unsigned TOTAL    = NUM_BANKS * BANK_PINS,
  localparam int unsigned BAW      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int unsigned AW       = BAW + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [TOTAL-1:0]    pins,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic [DED_PINS-1:0] irq_ded,
  output logic                irq_shared
);
  logic [TOTAL-1:0]                   pin_s;
  logic [NUM_BANKS-1:0][DW-1:0]       cfg_words;
  logic [NUM_BANKS-1:0][BANK_PINS-1:0] mask_b;
  logic [NUM_BANKS-1:0][BANK_PINS-1:0] pend_b;
  logic [TOTAL-1:0]                   active;
  logic [DW-1:0]                      rd_word;
  reg_kind_e                          kind;
  logic [BAW-1:0]                     bank_idx;
  logic                               wr_req;
  logic                               rd_req;

  assign kind     = reg_kind_e'(bus_addr[AW-1 -: 2]);
  assign bank_idx = bus_addr[BAW-1:0];
  assign wr_req   = bus_sel & bus_wr;
  assign rd_req   = bus_sel & ~bus_wr;

  eint_sync #(.WIDTH(TOTAL)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (pins),
    .d_sync  (pin_s)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = wr_req && (32'(bank_idx) == b);

    eint_bank #(.PINS(BANK_PINS), .DW(DW)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .pin_s    (pin_s[b*BANK_PINS +: BANK_PINS]),
      .cfg_we   (hit && kind == KIND_CFG),
      .mask_we  (hit && kind == KIND_MASK),
      .pend_we  (hit && kind == KIND_PEND),
      .wdata    (bus_wdata),
      .cfg_word (cfg_words[b]),
      .mask_q   (mask_b[b]),
      .pend_q   (pend_b[b])
    );
  end

  eint_rdmux #(.BANKS(NUM_BANKS), .PINS(BANK_PINS), .DW(DW)) u_rdmux (
    .kind      (kind),
    .bank      (bank_idx),
    .cfg_words (cfg_words),
    .masks     (mask_b),
    .pends     (pend_b),
    .word      (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_word;
  end

  assign active     = pend_b & ~mask_b;
  assign irq_ded    = active[DED_PINS-1:0];
  assign irq_shared = |active[TOTAL-1:DED_PINS];

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_req) |-> $stable(bus_rdata));
  // R1
  reset_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_ded == '0 && !irq_shared));
endmodule

// File: tb/test_eint_ctrl.sv
module test_eint_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pins = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] irq_ded;
  logic        irq_shared;

  int checks = 0;
  int fails  = 0;
  logic rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  localparam logic [1:0] K_CFG = 2'd0, K_MASK = 2'd1, K_PEND = 2'd2;

  always #10 clk = ~clk;

  eint_ctrl i_eint_ctrl (
    .clk(clk), .rst(rst), .pins(pins), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_ded(irq_ded), .irq_shared(irq_shared)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] kind, input logic [1:0] bank, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = {kind, bank}; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] kind, input logic [1:0] bank, input logic [31:0] exp, input string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = {kind, bank};
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // Monitor: a read captured at a rising edge is compared at the next falling edge
  always @(posedge clk) rd_seen <= bus_sel & ~bus_wr & ~rst;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    for (int b = 0; b < 4; b++) begin
      rd(K_CFG, 2'(b), 32'h0, "R1 cfg");
      rd(K_MASK, 2'(b), 32'hFF, "R1 mask");
    end
    check({15'b0, irq_shared, irq_ded}, 32'h0, "R1 outputs");

    for (int b = 0; b < 4; b++) wr(K_CFG, 2'(b), 32'h77777777);
    for (int b = 0; b < 4; b++) wr(K_PEND, 2'(b), 32'hFF);
    for (int b = 0; b < 4; b++) rd(K_PEND, 2'(b), 32'h0, "R6 idle pend");

    // R2 field layout
    wr(K_CFG, 2'd2, 32'h89ABCDEF);
    rd(K_CFG, 2'd2, 32'h01234567, "R2 field readback");
    wr(K_CFG, 2'd2, 32'h77777777);
    wr(K_PEND, 2'd2, 32'hFF);
    rd(K_PEND, 2'd2, 32'h0, "R8 pend2 cleared");

    // R6 unused codes
    wr(K_CFG, 2'd1, 32'h56565656);
    for (int k = 0; k < 4; k++) begin
      pins[15:0] = ~pins[15:0];
      step(4);
    end
    rd(K_PEND, 2'd1, 32'h0, "R6 codes 5/6");
    rd(K_PEND, 2'd0, 32'h0, "R6 code 7");
    pins[15:0] = '0;
    wr(K_CFG, 2'd1, 32'h77777777);
    step(4);

    // R3 level high, pin 3
    wr(K_CFG, 2'd0, 32'h77771777);
    pins[3] = 1'b1;
    step(3);
    rd(K_PEND, 2'd0, 32'h08, "R3 level high");
    wr(K_MASK, 2'd0, 32'hF7);
    check({16'b0, irq_ded}, 32'h0008, "R9 dedicated pin3");
    wr(K_PEND, 2'd0, 32'h08);
    rd(K_PEND, 2'd0, 32'h08, "R3 re-set after clear");
    pins[3] = 1'b0;
    step(3);
    wr(K_PEND, 2'd0, 32'h08);
    rd(K_PEND, 2'd0, 32'h0, "R3 level gone");
    check({16'b0, irq_ded}, 32'h0, "R9 pin3 cleared");

    // R3 level low, pin 10
    pins[10] = 1'b1;
    step(3);
    wr(K_CFG, 2'd1, 32'h77777077);
    step(1);
    rd(K_PEND, 2'd1, 32'h0, "R3 level low idle high");
    pins[10] = 1'b0;
    step(3);
    rd(K_PEND, 2'd1, 32'h04, "R3 level low active");
    pins[10] = 1'b1;
    step(3);
    wr(K_PEND, 2'd1, 32'h04);
    rd(K_PEND, 2'd1, 32'h0, "R8 level low cleared");

    // R4 rising, pin 17, with exact latency
    wr(K_CFG, 2'd2, 32'h77777737);
    wr(K_MASK, 2'd2, 32'hFD);
    pins[17] = 1'b1;
    step(2);
    check({31'b0, irq_shared}, 32'h0, "R4 not before third edge");
    step(1);
    check({31'b0, irq_shared}, 32'h1, "R4 R10 rising on third edge");
    wr(K_PEND, 2'd2, 32'h02);
    check({31'b0, irq_shared}, 32'h0, "R8 clear drops shared");
    rd(K_PEND, 2'd2, 32'h0, "R4 edge not re-set");
    pins[17] = 1'b0;
    step(4);
    rd(K_PEND, 2'd2, 32'h0, "R4 falling ignored in rise mode");

    // R4 falling, pin 26; R7 masked capture
    wr(K_CFG, 2'd3, 32'h77777277);
    pins[26] = 1'b1;
    step(4);
    rd(K_PEND, 2'd3, 32'h0, "R4 rising ignored in fall mode");
    pins[26] = 1'b0;
    step(3);
    rd(K_PEND, 2'd3, 32'h04, "R4 falling sets");
    check({31'b0, irq_shared}, 32'h0, "R7 masked keeps output low");
    wr(K_MASK, 2'd3, 32'hFB);
    check({31'b0, irq_shared}, 32'h1, "R7 R10 unmask exposes pending");
    wr(K_PEND, 2'd3, 32'h00);
    rd(K_PEND, 2'd3, 32'h04, "R8 write zero no effect");
    wr(K_PEND, 2'd3, 32'h04);
    rd(K_PEND, 2'd3, 32'h0, "R8 write one clears");
    check({31'b0, irq_shared}, 32'h0, "R10 shared low");

    // R5 both edges, pin 0
    wr(K_CFG, 2'd0, 32'h77777774);
    wr(K_MASK, 2'd0, 32'hF6);
    pins[0] = 1'b1;
    step(3);
    check({16'b0, irq_ded}, 32'h0001, "R5 R9 rise in both mode");
    wr(K_PEND, 2'd0, 32'h01);
    check({16'b0, irq_ded}, 32'h0, "R8 R9 cleared");
    pins[0] = 1'b0;
    step(3);
    check({16'b0, irq_ded}, 32'h0001, "R5 fall in both mode");
    wr(K_PEND, 2'd0, 32'h01);

    // R11 read data held
    rd(K_MASK, 2'd0, 32'hF6, "R11 read mask0");
    step(3);
    check(bus_rdata, 32'hF6, "R11 rdata held");

    step(2);
    finish_run();
  end
endmodule